// File: doc/BRIEF.md
# Reset-Time Pad Override Controller

This block decides, for each group of device pads, whether the output drivers must be forced into high impedance while a system reset is in progress. It takes the decoded reset requests (power-on, external warm, emulation warm, software cold, software warm and test) and a software-settable isolation bit. From these it produces one registered tri-state override per pad group. The groups are general, emulation, isolatable Ethernet-switch, reset-out and DDR address/control.

It also produces reset enables for the pin-control registers, split into the general set and the isolatable Ethernet-switch set. For the DDR group it produces a drive-to-pull-value enable that takes over when reset ends. The isolation bit lives inside the block. Only power-on reset clears it, so a software setting survives the warm resets it is meant to bypass. All control pins are plain levels; the block carries no data stream and so has no valid/ready handshake.

Top module: `rst_pad_ctrl`

## Requirements
- R1: While any reset request other than test reset is high, `pad_tz[0]` (general group) is 1 one clock later; with none of those requests high it is 0 one clock later.
- R2: `pad_tz[1]` (emulation group) is 1 one clock after a cycle with `rst_test` high and 0 one clock after a cycle with it low, whatever the other requests do.
- R3: A cycle with `rst_por` high makes `pad_tz[2]` (Ethernet-switch group) 1 one clock later, regardless of the isolation bit, and clears `iso_ctrl` to 0 at that clock.
- R4: Under a non-test reset without `rst_por`, `pad_tz[2]` one clock later is 0 when `iso_ctrl` was 1 and 1 when it was 0.
- R5: `pad_tz[3]` (reset-out pin) is 1 one clock later only if `rst_por` or `rst_ext` was high; every other reset leaves it at 0.
- R6: `pad_tz[4]` (DDR group) follows the same rule as R1. On the first clock at which the non-test resets have all gone low after being high, `ddr_pull_en` becomes 1. `ddr_pull_en` is never 1 together with `pad_tz[4]`.
- R7: Once set, `ddr_pull_en` stays 1 until a cycle with `padctl_wr` high clears it at the next clock, or until a new non-test reset clears it. Setting has priority over a simultaneous write.
- R8: `iso_wr` loads `iso_wdata` into `iso_ctrl` at the next clock when `rst_por` is low. Without `iso_wr` or `rst_por`, `iso_ctrl` holds, including through warm, software and test resets.
- R9: `pinctl_rst_gen` equals `pad_tz[0]`'s rule. `pinctl_rst_eth` equals `pad_tz[2]`'s rule: the isolated Ethernet-switch pin-control registers are not reset under a non-power-on reset while isolation is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_por | input | 1 | Power-on reset request, active high |
| rst_ext | input | 1 | External warm reset pin request |
| rst_emu_warm | input | 1 | Emulation warm reset request |
| rst_sw_cold | input | 1 | Software global cold reset request |
| rst_sw_warm | input | 1 | Software global warm reset request |
| rst_test | input | 1 | Test reset request |
| iso_wr | input | 1 | Write strobe for the isolation bit |
| iso_wdata | input | 1 | Value written to the isolation bit |
| padctl_wr | input | 1 | Software write to the DDR pad-control register |
| pad_tz | output | 5 | Tri-state override per group: [0] general, [1] emulation, [2] Ethernet-switch, [3] reset-out, [4] DDR |
| ddr_pull_en | output | 1 | Drive DDR pads to their pull values |
| pinctl_rst_gen | output | 1 | Reset enable for general pin-control registers |
| pinctl_rst_eth | output | 1 | Reset enable for isolatable Ethernet-switch pin-control registers |
| iso_ctrl | output | 1 | Current isolation bit |

## Verification
The bench drives all 64 combinations of the six reset requests, once with the isolation bit clear and once with it set. This tells apart the groups that differ only in which request they ignore: test reset alone, external against the other warm resets, and power-on against isolation. After each combination the requests are released. The bench then checks that the DDR pull enable appears only when a non-test reset had been active, that it survives idle cycles, and that only a pad-control write clears it. It also checks that the isolation bit survives every combination without power-on reset.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int NGRP = 5;
  localparam int G_GEN    = 0;
  localparam int G_EMU    = 1;
  localparam int G_ETH    = 2;
  localparam int G_RSTOUT = 3;
  localparam int G_DDR    = 4;

  typedef struct packed {
    logic por;
    logic ext;
    logic emu_warm;
    logic sw_cold;
    logic sw_warm;
    logic test;
  } rst_req_t;
endpackage

// File: rtl/rpc_iso_reg.sv
module rpc_iso_reg (
  input  logic clk,
  input  logic clr,
  input  logic wr,
  input  logic wdata,
  output logic q
);
  // Only the power-on request clears the bit; warm resets leave it alone.
  always_ff @(posedge clk) begin
    if (clr)     q <= 1'b0;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/rpc_group_rules.sv
module rpc_group_rules
  import rpc_pkg::*;
(
  input  rst_req_t         req,
  input  logic             iso,
  output logic [NGRP-1:0]  tz_next,
  output logic             sys_rst,
  output logic             eth_rst
);
  logic sys_any;
  assign sys_any = req.por | req.ext | req.emu_warm | req.sw_cold | req.sw_warm;
  assign sys_rst = sys_any;
  assign eth_rst = req.por | (sys_any & ~iso);

  for (genvar g = 0; g < NGRP; g++) begin : g_rule
    if (g == G_EMU) begin : g_emu
      assign tz_next[g] = req.test;
    end else if (g == G_ETH) begin : g_eth
      assign tz_next[g] = eth_rst;
    end else if (g == G_RSTOUT) begin : g_ro
      assign tz_next[g] = req.por | req.ext;
    end else begin : g_plain
      assign tz_next[g] = sys_any;
    end
  end
endmodule

// File: rtl/rpc_ddr_release.sv
module rpc_ddr_release (
  input  logic clk,
  input  logic sys_rst,
  input  logic padctl_wr,
  output logic pull_en
);
  logic sys_d;

  always_ff @(posedge clk) begin
    sys_d <= sys_rst;
    if (sys_rst)        pull_en <= 1'b0;
    else if (sys_d)     pull_en <= 1'b1;
    else if (padctl_wr) pull_en <= 1'b0;
  end
endmodule

// File: rtl/rst_pad_ctrl.sv
module rst_pad_ctrl
  import rpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_por,
  input  logic            rst_ext,
  input  logic            rst_emu_warm,
  input  logic            rst_sw_cold,
  input  logic            rst_sw_warm,
  input  logic            rst_test,
  input  logic            iso_wr,
  input  logic            iso_wdata,
  input  logic            padctl_wr,
  output logic [NGRP-1:0] pad_tz,
  output logic            ddr_pull_en,
  output logic            pinctl_rst_gen,
  output logic            pinctl_rst_eth,
  output logic            iso_ctrl
);
  rst_req_t        req;
  logic [NGRP-1:0] tz_next;
  logic            sys_rst, eth_rst;

  assign req = '{por: rst_por, ext: rst_ext, emu_warm: rst_emu_warm,
                 sw_cold: rst_sw_cold, sw_warm: rst_sw_warm, test: rst_test};

  rpc_iso_reg i_iso (
    .clk(clk), .clr(rst_por), .wr(iso_wr), .wdata(iso_wdata), .q(iso_ctrl)
  );

  rpc_group_rules i_rules (
    .req(req), .iso(iso_ctrl), .tz_next(tz_next),
    .sys_rst(sys_rst), .eth_rst(eth_rst)
  );

  rpc_ddr_release i_ddr (
    .clk(clk), .sys_rst(sys_rst), .padctl_wr(padctl_wr), .pull_en(ddr_pull_en)
  );

  // All overrides leave from flops so groups switch on the same edge.
  always_ff @(posedge clk) begin
    pad_tz         <= tz_next;
    pinctl_rst_gen <= sys_rst;
    pinctl_rst_eth <= eth_rst;
  end
endmodule

// File: rtl/rst_pad_ctrl_chk.sv
module rst_pad_ctrl_chk
  import rpc_pkg::*;
(
  input logic            clk,
  input logic            rst_por,
  input logic            rst_ext,
  input logic            rst_emu_warm,
  input logic            rst_sw_cold,
  input logic            rst_sw_warm,
  input logic            rst_test,
  input logic            iso_wr,
  input logic            iso_wdata,
  input logic            padctl_wr,
  input logic [NGRP-1:0] pad_tz,
  input logic            ddr_pull_en,
  input logic            pinctl_rst_gen,
  input logic            pinctl_rst_eth,
  input logic            iso_ctrl
);
  logic warm;
  assign warm = rst_ext | rst_emu_warm | rst_sw_cold | rst_sw_warm;

  AST_GEN_TRISTATE: assert property (@(posedge clk) disable iff (rst_por)
    warm |=> pad_tz[G_GEN]); // R1
  AST_EMU_TEST_ONLY: assert property (@(posedge clk) disable iff (rst_por)
    1'b1 |=> (pad_tz[G_EMU] == $past(rst_test))); // R2
  AST_ETH_ISO_HOLD: assert property (@(posedge clk) disable iff (rst_por)
    (warm && iso_ctrl) |=> !pad_tz[G_ETH]); // R4
  AST_RSTOUT_KEEP: assert property (@(posedge clk) disable iff (rst_por)
    !rst_ext |=> !pad_tz[G_RSTOUT]); // R5
  AST_DDR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst_por)
    !(ddr_pull_en && pad_tz[G_DDR])); // R6
  AST_DDR_PULL_HOLD: assert property (@(posedge clk) disable iff (rst_por)
    (ddr_pull_en && !padctl_wr && !warm) |=> ddr_pull_en); // R7
  AST_ISO_STABLE: assert property (@(posedge clk) disable iff (rst_por)
    !iso_wr |=> $stable(iso_ctrl)); // R8
  AST_ETH_REG_MATCH: assert property (@(posedge clk) disable iff (rst_por)
    1'b1 |=> (pinctl_rst_eth == pad_tz[G_ETH])); // R9
endmodule

bind rst_pad_ctrl rst_pad_ctrl_chk i_chk (.*);

// File: tb/test_rst_pad_ctrl.sv
module test_rst_pad_ctrl;
  logic clk = 1'b0;
  logic rst_por, rst_ext, rst_emu_warm, rst_sw_cold, rst_sw_warm, rst_test;
  logic iso_wr, iso_wdata, padctl_wr;
  logic [4:0] pad_tz;
  logic ddr_pull_en, pinctl_rst_gen, pinctl_rst_eth, iso_ctrl;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_pad_ctrl i_rst_pad_ctrl (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] c);
    {rst_test, rst_sw_warm, rst_sw_cold, rst_emu_warm, rst_ext, rst_por} = c;
  endtask

  task automatic set_iso(logic v);
    iso_wr = 1'b1; iso_wdata = v;
    tick();
    iso_wr = 1'b0;
    chk("R8 iso write", {7'd0, iso_ctrl}, {7'd0, v});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    iso_wr = 0; iso_wdata = 0; padctl_wr = 0;
    @(negedge clk);
    drive(6'b000001);
    repeat (3) tick();
    chk("R1 R3 R5 R6 reset tz", {3'd0, pad_tz}, 8'b0001_0101 | 8'b0000_1000);
    chk("R3 iso cleared", {7'd0, iso_ctrl}, 8'd0);
    chk("R9 reset enables", {6'd0, pinctl_rst_gen, pinctl_rst_eth}, 8'd3);
    chk("R6 no pull during reset", {7'd0, ddr_pull_en}, 8'd0);
    drive(6'b0);
    tick();
    chk("R6 pull after release", {7'd0, ddr_pull_en}, 8'd1);
    padctl_wr = 1; tick(); padctl_wr = 0;
    chk("R7 write clears pull", {7'd0, ddr_pull_en}, 8'd0);

    for (int iso = 0; iso < 2; iso++) begin
      for (int c = 0; c < 64; c++) begin
        logic por, ext, tst, sys, ethr, iso_exp;
        logic [4:0] exp_tz;
        por = c[0]; ext = c[1]; tst = c[5];
        sys = |c[4:0];
        ethr = por | (sys & ~iso[0]);
        exp_tz = {sys, por | ext, ethr, tst, sys};
        iso_exp = por ? 1'b0 : iso[0];
        set_iso(iso[0]);
        drive(c[5:0]);
        tick();
        chk("R1 R2 R3 R4 R5 R6 tz", {3'd0, pad_tz}, {3'd0, exp_tz});
        chk("R9 pinctl enables", {6'd0, pinctl_rst_gen, pinctl_rst_eth}, {6'd0, sys, ethr});
        chk("R6 no pull while reset", {7'd0, ddr_pull_en}, 8'd0 | {7'd0, ddr_pull_en & ~sys});
        chk("R3 R8 iso through reset", {7'd0, iso_ctrl}, {7'd0, iso_exp});
        drive(6'b0);
        tick();
        chk("R10 tz idle", {3'd0, pad_tz}, 8'd0);
        if (sys) chk("R6 pull on release", {7'd0, ddr_pull_en}, 8'd1);
        repeat (2) tick();
        if (sys) chk("R7 pull holds", {7'd0, ddr_pull_en}, 8'd1);
        padctl_wr = 1; tick(); padctl_wr = 0;
        chk("R7 write clears", {7'd0, ddr_pull_en}, 8'd0);
      end
    end

    // R7: release and write on the same edge, set wins
    drive(6'b000010); tick();
    drive(6'b0); padctl_wr = 1; tick(); padctl_wr = 0;
    chk("R7 set priority", {7'd0, ddr_pull_en}, 8'd1);
    // R7: new reset clears pull
    drive(6'b010000); tick();
    chk("R7 reset clears pull", {7'd0, ddr_pull_en}, 8'd0);
    drive(6'b0); tick();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule